// File: doc/BRIEF.md
# Byte and Pair Register File with Indirect Operand

This block holds the working state of a small 8-bit processor. It keeps eight byte registers (B, C, D, E, H, L, the accumulator A and the flag byte F), a 16-bit stack pointer and a 16-bit program counter. Decode logic reaches the bytes through a 3-bit operand code and the 16-bit pairs through a 2-bit pair code. A 2-bit condition code is tested against the flag byte to resolve branches.

Operand code 6 names no register. It stands for the memory byte addressed by the HL pair. When an access uses that code, the block raises a combinational memory strobe that carries the HL address. A write also drives the write enable and the data. A read returns the memory data as the operand. Internally the bytes are stored in the order B, C, D, E, H, L, A, F. Code 7 therefore maps to slot 6, and each pair is assembled from two adjacent slots.

Top module: `cpu_regfile`

## Requirements
- R1: While reset is held low, and after its release until the first write, every byte register reads 0, the program counter equals PC_INIT and pair code 3 reads SP_INIT.
- R2: Byte operand codes 0,1,2,3,4,5 address B,C,D,E,H,L, and code 7 addresses A. A byte written on one clock edge is returned on the combinational read port from then on.
- R3: An access with byte code 6 asserts mem_req with mem_addr equal to {H,L}. A read of code 6 returns mem_rdata. A write of code 6 asserts mem_we with mem_wdata equal to the write data and changes no register.
- R4: Pair codes 0,1,2 read and write {B,C}, {D,E} and {H,L}, high byte first. A pair write changes both bytes on the same edge, and the bytes are visible through the byte port.
- R5: Pair code 3 reads and writes the stack pointer and touches no byte register.
- R6: When a pair write and a byte write hit the same register on one edge, the pair value is stored.
- R7: The flag port loads F, and F is presented on flags. Bit 7 is zero, bit 6 subtract, bit 5 half-carry and bit 4 carry.
- R8: The condition output is true for code 0 when F bit 7 is 0, for code 1 when it is 1, for code 2 when F bit 4 is 0, and for code 3 when it is 1.
- R9: The program counter loads pc_wdata when pc_we is high and otherwise holds its value.
- R10: mem_req is low in any cycle without a code 6 read or write. mem_we is high only for a code 6 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Byte read request |
| rd_sel | input | 3 | Byte read operand code |
| rd_data | output | 8 | Byte read result |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 3 | Byte write operand code |
| wr_data | input | 8 | Byte write data |
| pr_rd_sel | input | 2 | Pair read code |
| pr_rd_data | output | 16 | Pair read result |
| pr_we | input | 1 | Pair write enable |
| pr_wr_sel | input | 2 | Pair write code |
| pr_wdata | input | 16 | Pair write data |
| flag_we | input | 1 | Flag byte write enable |
| flag_wdata | input | 8 | Flag byte write data |
| flags | output | 8 | Current flag byte |
| cond_sel | input | 2 | Branch condition code |
| cond_true | output | 1 | Condition result |
| pc_we | input | 1 | Program counter load |
| pc_wdata | input | 16 | Program counter load value |
| pc | output | 16 | Program counter |
| mem_req | output | 1 | Indirect memory strobe |
| mem_we | output | 1 | Indirect memory write enable |
| mem_addr | output | 16 | Indirect address (HL) |
| mem_wdata | output | 8 | Indirect write data |
| mem_rdata | input | 8 | Indirect read data |

## Verification
The assertions watch, on every cycle, that the strobe appears only for code 6, that a write enable never appears without the strobe, and that the indirect address follows the last HL pair write. They also check that a pair written on one edge reads back on the next, that the program counter loads or holds, and that the zero and carry conditions follow the last flag load. Only the bench scenarios can show the operand remapping from end to end, the internal slot order seen through both the byte port and the pair port, the reset contents, and the precedence of a pair write over a colliding byte write.

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter logic [15:0] PC_INIT = 16'h0100,
  parameter logic [15:0] SP_INIT = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [2:0]  rd_sel,
  output logic [7:0]  rd_data,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  pr_rd_sel,
  output logic [15:0] pr_rd_data,
  input  logic        pr_we,
  input  logic [1:0]  pr_wr_sel,
  input  logic [15:0] pr_wdata,
  input  logic        flag_we,
  input  logic [7:0]  flag_wdata,
  output logic [7:0]  flags,
  input  logic [1:0]  cond_sel,
  output logic        cond_true,
  input  logic        pc_we,
  input  logic [15:0] pc_wdata,
  output logic [15:0] pc,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  localparam logic [2:0] IND = 3'd6;

  logic [7:0]  slot [8];
  logic [15:0] sp_q;
  logic [15:0] pc_q;
  logic [2:0]  rd_idx, wr_idx;
  logic        rd_ind, wr_ind;

  assign rd_idx = (rd_sel == 3'd7) ? 3'd6 : rd_sel;
  assign wr_idx = (wr_sel == 3'd7) ? 3'd6 : wr_sel;
  assign rd_ind = rd_en && (rd_sel == IND);
  assign wr_ind = wr_en && (wr_sel == IND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) slot[i] <= 8'h00;
      sp_q <= SP_INIT;
      pc_q <= PC_INIT;
    end else begin
      if (wr_en && !wr_ind) slot[wr_idx] <= wr_data;
      if (flag_we) slot[7] <= flag_wdata;
      if (pr_we) begin
        if (pr_wr_sel == 2'd3) sp_q <= pr_wdata;
        else begin
          slot[{pr_wr_sel, 1'b0}] <= pr_wdata[15:8];
          slot[{pr_wr_sel, 1'b1}] <= pr_wdata[7:0];
        end
      end
      if (pc_we) pc_q <= pc_wdata;
    end
  end

  assign rd_data    = (rd_sel == IND) ? mem_rdata : slot[rd_idx];
  assign pr_rd_data = (pr_rd_sel == 2'd3) ? sp_q
                    : {slot[{pr_rd_sel, 1'b0}], slot[{pr_rd_sel, 1'b1}]};
  assign flags      = slot[7];
  assign pc         = pc_q;

  always_comb begin
    case (cond_sel)
      2'd0:    cond_true = !slot[7][7];
      2'd1:    cond_true = slot[7][7];
      2'd2:    cond_true = !slot[7][4];
      default: cond_true = slot[7][4];
    endcase
  end

  assign mem_req   = rd_ind || wr_ind;
  assign mem_we    = wr_ind;
  assign mem_addr  = {slot[4], slot[5]};
  assign mem_wdata = wr_data;
endmodule

// File: rtl/cpu_regfile_chk.sv
module cpu_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [2:0]  rd_sel,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [1:0]  pr_rd_sel,
  input logic [15:0] pr_rd_data,
  input logic        pr_we,
  input logic [1:0]  pr_wr_sel,
  input logic [15:0] pr_wdata,
  input logic        flag_we,
  input logic [7:0]  flag_wdata,
  input logic [1:0]  cond_sel,
  input logic        cond_true,
  input logic        pc_we,
  input logic [15:0] pc_wdata,
  input logic [15:0] pc,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr
);
  a_r10_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  a_r10_no_req_without_ind: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_en && rd_sel == 3'd6) && !(wr_en && wr_sel == 3'd6)) |-> !mem_req);

  a_r3_addr_follows_hl: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pr_we && pr_wr_sel == 2'd2) && mem_req) |-> mem_addr == $past(pr_wdata));

  a_r4_pair_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pr_we) && pr_rd_sel == $past(pr_wr_sel)) |-> pr_rd_data == $past(pr_wdata));

  a_r9_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> pc == $past(pc_wdata));

  a_r9_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc));

  a_r8_zero_cond: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_we) && cond_sel == 2'd1) |-> cond_true == $past(flag_wdata[7]));

  a_r8_carry_cond: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_we) && cond_sel == 2'd3) |-> cond_true == $past(flag_wdata[4]));
endmodule

bind cpu_regfile cpu_regfile_chk u_chk (.*);

// File: tb/cpu_regfile_tb.sv
module cpu_regfile_tb;
  localparam logic [15:0] PCI = 16'h0100;
  localparam logic [15:0] SPI = 16'hFFFE;

  logic clk = 0, rst_n = 0;
  logic rd_en = 0, wr_en = 0, pr_we = 0, flag_we = 0, pc_we = 0;
  logic [2:0] rd_sel = 0, wr_sel = 0;
  logic [7:0] wr_data = 0, flag_wdata = 0, mem_rdata = 0;
  logic [1:0] pr_rd_sel = 0, pr_wr_sel = 0, cond_sel = 0;
  logic [15:0] pr_wdata = 0, pc_wdata = 0;
  logic [7:0] rd_data, flags, mem_wdata;
  logic [15:0] pr_rd_data, pc, mem_addr;
  logic cond_true, mem_req, mem_we;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m [8];
  logic [15:0] msp, mpc;

  always #4 clk = ~clk;

  cpu_regfile #(.PC_INIT(PCI), .SP_INIT(SPI)) u_dut (.*);

  function automatic int bidx(input logic [2:0] c);
    return (c == 3'd7) ? 6 : int'(c);
  endfunction

  function automatic logic [15:0] pair(input logic [1:0] p);
    if (p == 2'd3) return msp;
    return {m[2*p], m[2*p+1]};
  endfunction

  function automatic logic cond(input logic [1:0] c);
    case (c)
      2'd0: return !m[7][7];
      2'd1: return m[7][7];
      2'd2: return !m[7][4];
      default: return m[7][4];
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk(rd_sel == 3'd6 ? "R3 ind read" : "R2 byte read", {24'h0, rd_data},
        {24'h0, rd_sel == 3'd6 ? mem_rdata : m[bidx(rd_sel)]});
    chk(pr_rd_sel == 2'd3 ? "R5 sp read" : "R4 pair read", {16'h0, pr_rd_data}, {16'h0, pair(pr_rd_sel)});
    chk("R7 flags", {24'h0, flags}, {24'h0, m[7]});
    chk("R8 cond", {31'h0, cond_true}, {31'h0, cond(cond_sel)});
    chk("R9 pc", {16'h0, pc}, {16'h0, mpc});
    chk("R10 mem_req", {31'h0, mem_req},
        {31'h0, (rd_en && rd_sel == 3'd6) || (wr_en && wr_sel == 3'd6)});
    chk("R10 mem_we", {31'h0, mem_we}, {31'h0, wr_en && wr_sel == 3'd6});
    if (mem_req) chk("R3 addr", {16'h0, mem_addr}, {16'h0, m[4], m[5]});
    if (mem_we) chk("R3 wdata", {24'h0, mem_wdata}, {24'h0, wr_data});
  endtask

  task automatic model_step();
    if (wr_en && wr_sel != 3'd6) m[bidx(wr_sel)] = wr_data;
    if (flag_we) m[7] = flag_wdata;
    if (pr_we) begin
      if (pr_wr_sel == 2'd3) msp = pr_wdata;
      else begin
        m[2*pr_wr_sel] = pr_wdata[15:8];
        m[2*pr_wr_sel+1] = pr_wdata[7:0];
      end
    end
    if (pc_we) mpc = pc_wdata;
  endtask

  task automatic idle();
    rd_en = 0; wr_en = 0; pr_we = 0; flag_we = 0; pc_we = 0;
  endtask

  task automatic cycle();
    #1 check_all();
    model_step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    msp = SPI; mpc = PCI;
    repeat (3) @(negedge clk);
    // R1: contents during reset
    for (int c = 0; c < 8; c++) begin
      rd_sel = 3'(c);
      #1 if (c != 6) chk("R1 reset byte", {24'h0, rd_data}, 32'h0);
    end
    pr_rd_sel = 2'd3; #1 chk("R1 reset sp", {16'h0, pr_rd_data}, {16'h0, SPI});
    chk("R1 reset pc", {16'h0, pc}, {16'h0, PCI});
    rst_n = 1;
    @(negedge clk); #1 chk("R1 after release pc", {16'h0, pc}, {16'h0, PCI});

    // R2: every byte code written then read
    for (int c = 0; c < 8; c++) begin
      if (c == 6) continue;
      @(negedge clk); idle(); wr_en = 1; wr_sel = 3'(c); wr_data = 8'h10 + 8'(c); cycle();
      @(negedge clk); idle(); rd_en = 1; rd_sel = 3'(c); cycle();
    end
    // R4: pair HL then byte views H and L
    @(negedge clk); idle(); pr_we = 1; pr_wr_sel = 2'd2; pr_wdata = 16'hC0DE; cycle();
    @(negedge clk); idle(); rd_sel = 3'd4; cycle();
    @(negedge clk); idle(); rd_sel = 3'd5; cycle();
    // R3: indirect write leaves array unchanged
    @(negedge clk); idle(); wr_en = 1; wr_sel = 3'd6; wr_data = 8'h5A; rd_en = 1; rd_sel = 3'd6;
    mem_rdata = 8'hA7; cycle();
    @(negedge clk); idle(); pr_rd_sel = 2'd2; cycle();
    // R5: sp write
    @(negedge clk); idle(); pr_we = 1; pr_wr_sel = 2'd3; pr_wdata = 16'h1234; cycle();
    @(negedge clk); idle(); pr_rd_sel = 2'd3; cycle();
    // R6: collision, pair DE vs byte E
    @(negedge clk); idle(); pr_we = 1; pr_wr_sel = 2'd1; pr_wdata = 16'hBEEF;
    wr_en = 1; wr_sel = 3'd3; wr_data = 8'h77; cycle();
    @(negedge clk); idle(); rd_sel = 3'd3; #1 chk("R6 pair wins", {24'h0, rd_data}, 32'hEF);
    // R7/R8: flag patterns
    for (int f = 0; f < 4; f++) begin
      @(negedge clk); idle(); flag_we = 1; flag_wdata = {f[1], 2'b00, f[0], 4'h0}; cycle();
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); idle(); cond_sel = 2'(c); cycle();
      end
    end
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      rd_en = 1'($urandom); rd_sel = 3'($urandom); wr_en = 1'($urandom);
      wr_sel = 3'($urandom); wr_data = 8'($urandom); pr_rd_sel = 2'($urandom);
      pr_we = ($urandom % 3) == 0; pr_wr_sel = 2'($urandom); pr_wdata = 16'($urandom);
      flag_we = ($urandom % 4) == 0; flag_wdata = 8'($urandom); cond_sel = 2'($urandom);
      pc_we = ($urandom % 4) == 0; pc_wdata = 16'($urandom); mem_rdata = 8'($urandom);
      cycle();
    end
    @(negedge clk); idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule